// File: doc/BRIEF.md
# Triggered Sampling Stop Controller

This block sequences a multi-channel switched-capacitor waveform sampler. A free-running coarse counter runs on the main clock. While the sampler is armed, a circular write pointer steps through the analog storage cells, one cell per clock. Every discriminator hit input is registered, and only a rising edge is acted on. When any channel rises, the controller records the coarse count and the set of channels that rose. It then keeps writing for a programmable number of further clocks, so the tail of the pulse is still captured, and then stops writing.

When writing stops, the controller latches the address of the last cell written. A later stage can use that address with the coarse timestamp to place the stored waveform in time. The controller then requests readout. The readout side acknowledges the request, and later signals completion, which re-arms the controller. Trigger timing is resolved only to one main-clock period, for example 2 ns at 500 MHz. Fine interpolation, the analog storage and the conversion belong to other blocks.

Top module: `trig_stop_seq`

## Requirements
- R1: While rst_ni is low: wr_ptr_o=0, coarse_o=0, wr_en_o=1 (armed), frozen_o=0, rd_req_o=0.
- R2: coarse_o increases by one on every rising clock edge and wraps from 2^CNT_W-1 to 0, whatever the state.
- R3: While wr_en_o=1, wr_ptr_o advances by one per clock, modulo DEPTH (default 256). While wr_en_o=0 it holds its value.
- R4: Each hit_i bit is registered, and a channel triggers in the first cycle in which its registered value is 1 and was 0 the cycle before. That cycle is the detection cycle. When armed, stamp_o takes the coarse_o value of the detection cycle, and trig_ch_o takes the mask of all channels that rose in that cycle. Bit k of the mask stands for hit_i[k].
- R5: With post-trigger delay D = delay_i in the detection cycle, wr_ench_o falls at the (D+1)-th rising edge after the detection cycle begins. With D=0, the cycle right after detection is already frozen. frozen_o rises together with the fall of wr_en_o.
- R6: stop_cell_o is the last cell written: (wr_ptr_o in the detection cycle + D) mod DEPTH. While frozen, wr_ptr_o equals stop_cell_o+1 mod DEPTH.
- R7: Rising hits after detection, while waiting, frozen or in readout, are ignored. stamp_o, trig_ch_o, stop_cell_o and the freeze cycle are unchanged.
- R8: A hit held high through re-arming does not trigger again. Only a new 0-to-1 transition triggers.
- R9: rd_req_o is 1 in the frozen state. A one-cycle rd_ack_i moves the controller to readout, where rd_req_o=0 and frozen_o stays 1. A rd_done_i in readout returns the controller to armed on the next edge, with frozen_o=0 and writing resumed. rd_ack_i outside the frozen state and rd_done_i outside readout are ignored.
- R10: delay_i is sampled only in the detection cycle. Changing it while waiting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_i | input | NUM_CH | Discriminator hits, one per channel |
| delay_i | input | DLY_W | Post-trigger delay in clocks |
| rd_ack_i | input | 1 | Readout accepts the frozen record |
| rd_done_i | input | 1 | Readout finished; re-arm |
| wr_en_o | output | 1 | Storage cell write enable |
| wr_ptr_o | output | PTR_W | Cell being written |
| coarse_o | output | CNT_W | Free-running coarse count |
| frozen_o | output | 1 | Writing stopped, record held |
| rd_req_o | output | 1 | Record ready for readout |
| stamp_o | output | CNT_W | Coarse count at detection |
| stop_cell_o | output | PTR_W | Last cell written before freeze |
| trig_ch_o | output | NUM_CH | Channels that rose at detection |

## Verification
A pointer or delay counter that is off by one shows up within one record as a wrong stop_cell_o, or as wr_en_o falling one clock early or late against the delay. A state machine that accepts a late trigger corrupts stamp_o or trig_ch_o in the same record. A wrong handshake decode leaves the block frozen, or makes it resume early, within a cycle of the stray pulse. The bench sweeps the delay through 0 to 40 and 255 across all channels, so pointer wrap and the edge cases of the delay counter are all reached.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_POST    = 2'd1,
    ST_FROZEN  = 2'd2,
    ST_READOUT = 2'd3
  } tss_state_e;
endpackage

// File: rtl/tss_coarse_cnt.sv
module tss_coarse_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/tss_trig_edge.sv
module tss_trig_edge #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hit_i,
  output logic [NUM_CH-1:0] rise_o,
  output logic              any_o
);
  logic [NUM_CH-1:0] hit_q, hit_d;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_q[c] <= 1'b0;
        hit_d[c] <= 1'b0;
      end else begin
        hit_q[c] <= hit_i[c];
        hit_d[c] <= hit_q[c];
      end
    end
    assign rise_o[c] = hit_q[c] & ~hit_d[c];
  end

  assign any_o = |rise_o;
endmodule

// File: rtl/tss_wr_ptr.sv
module tss_wr_ptr #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + PTR_W'(1);
  end
endmodule

// File: rtl/tss_fsm.sv
module tss_fsm
  import tss_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             rd_ack_i,
  input  logic             rd_done_i,
  output tss_state_e       state_o,
  output logic             capture_o,
  output logic             freeze_o
);
  tss_state_e       state_q, state_d;
  logic [DLY_W-1:0] dly_q;
  logic             dly_zero;

  assign dly_zero  = (delay_i == '0);
  assign capture_o = (state_q == ST_ARMED) && trig_i;
  assign freeze_o  = (capture_o && dly_zero) ||
                     ((state_q == ST_POST) && (dly_q == '0));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED:   if (trig_i)    state_d = dly_zero ? ST_FROZEN : ST_POST;
      ST_POST:    if (dly_q == '0) state_d = ST_FROZEN;
      ST_FROZEN:  if (rd_ack_i)  state_d = ST_READOUT;
      ST_READOUT: if (rd_done_i) state_d = ST_ARMED;
      default:                   state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARMED;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      // delay captured once at detection; remaining count excludes this cycle
      if (capture_o && !dly_zero)                dly_q <= delay_i - DLY_W'(1);
      else if (state_q == ST_POST && dly_q != '0) dly_q <= dly_q - DLY_W'(1);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/trig_stop_seq.sv
module trig_stop_seq
  import tss_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DLY_W  = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              rd_ack_i,
  input  logic              rd_done_i,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic [CNT_W-1:0]  coarse_o,
  output logic              frozen_o,
  output logic              rd_req_o,
  output logic [CNT_W-1:0]  stamp_o,
  output logic [PTR_W-1:0]  stop_cell_o,
  output logic [NUM_CH-1:0] trig_ch_o
);
  tss_state_e        state;
  logic [NUM_CH-1:0] rise;
  logic              trig_any, capture, freeze;

  tss_coarse_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(coarse_o)
  );

  tss_trig_edge #(.NUM_CH(NUM_CH)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_i),
    .rise_o(rise), .any_o(trig_any)
  );

  tss_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_any), .delay_i(delay_i),
    .rd_ack_i(rd_ack_i), .rd_done_i(rd_done_i),
    .state_o(state), .capture_o(capture), .freeze_o(freeze)
  );

  assign wr_en_o  = (state == ST_ARMED) || (state == ST_POST);
  assign frozen_o = (state == ST_FROZEN) || (state == ST_READOUT);
  assign rd_req_o = (state == ST_FROZEN);

  tss_wr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(wr_en_o), .ptr_o(wr_ptr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_o     <= '0;
      trig_ch_o   <= '0;
      stop_cell_o <= '0;
    end else begin
      if (capture) begin
        stamp_o   <= coarse_o;
        trig_ch_o <= rise;
      end
      if (freeze) stop_cell_o <= wr_ptr_o;
    end
  end
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_done_i,
  input logic              wr_en_o,
  input logic [PTR_W-1:0]  wr_ptr_o,
  input logic [CNT_W-1:0]  coarse_o,
  input logic              frozen_o,
  input logic              rd_req_o,
  input logic [CNT_W-1:0]  stamp_o,
  input logic [PTR_W-1:0]  stop_cell_o,
  input logic [NUM_CH-1:0] trig_ch_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  p_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> coarse_o == $past(coarse_o) + CNT_W'(1));

  p_ptr_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> wr_ptr_o == (($past(wr_ptr_o) == LAST) ? '0 : $past(wr_ptr_o) + PTR_W'(1)));

  p_ptr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |=> $stable(wr_ptr_o));

  p_frozen_nowr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |-> !wr_en_o);

  p_stop_next_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |-> wr_ptr_o == ((stop_cell_o == LAST) ? '0 : stop_cell_o + PTR_W'(1)));

  p_record_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |=> !frozen_o || ($stable(stamp_o) && $stable(stop_cell_o) && $stable(trig_ch_o)));

  p_req_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> frozen_o);

  p_rearm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && !rd_req_o && rd_done_i) |=> (!frozen_o && wr_en_o));
endmodule

bind trig_stop_seq tss_checker #(
  .NUM_CH(NUM_CH), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_done_i(rd_done_i),
  .wr_en_o(wr_en_o), .wr_ptr_o(wr_ptr_o), .coarse_o(coarse_o),
  .frozen_o(frozen_o), .rd_req_o(rd_req_o), .stamp_o(stamp_o),
  .stop_cell_o(stop_cell_o), .trig_ch_o(trig_ch_o)
);

// File: tb/trig_stop_seq_tb.sv
module trig_stop_seq_tb;
  localparam int NUM_CH = 4;
  localparam int DEPTH  = 256;
  localparam int CNT_W  = 12;
  localparam int DLY_W  = 8;
  localparam int PTR_W  = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NUM_CH-1:0] hit_i = '0;
  logic [DLY_W-1:0]  delay_i = '0;
  logic              rd_ack_i = 1'b0, rd_done_i = 1'b0;
  logic              wr_en_o, frozen_o, rd_req_o;
  logic [PTR_W-1:0]  wr_ptr_o, stop_cell_o;
  logic [CNT_W-1:0]  coarse_o, stamp_o;
  logic [NUM_CH-1:0] trig_ch_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  trig_stop_seq #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .CNT_W(CNT_W), .DLY_W(DLY_W)) u_dut (
    .clk_i, .rst_ni, .hit_i, .delay_i, .rd_ack_i, .rd_done_i,
    .wr_en_o, .wr_ptr_o, .coarse_o, .frozen_o, .rd_req_o,
    .stamp_o, .stop_cell_o, .trig_ch_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One record: trigger channel mask m with delay d; options inject noise.
  task automatic run_rec(input logic [NUM_CH-1:0] m, input int d,
                         input bit noise, input bit hold);
    int p_det, c_det, exp_stop;
    bit early;
    @(negedge clk_i);
    hit_i = m; delay_i = DLY_W'(d);
    @(negedge clk_i);                      // detection cycle
    p_det = int'(wr_ptr_o); c_det = int'(coarse_o);
    if (!hold) hit_i = '0;
    exp_stop = (p_det + d) % DEPTH;
    early = 0;
    for (int k = 0; k < d; k++) begin
      if (noise && k == 1) begin hit_i = ~m; delay_i = '0; rd_done_i = 1'b1; end
      if (noise && k == 2) begin hit_i = '0; rd_done_i = 1'b0; end
      @(negedge clk_i);
      if (!wr_en_o || frozen_o) early = 1;
    end
    if (noise && d < 3) begin hit_i = hold ? m : '0; rd_done_i = 1'b0; end
    @(negedge clk_i);
    chk("R5 written until delay expiry", int'(early), 0);
    chk("R5 wr_en low at freeze", int'(wr_en_o), 0);
    chk("R5 frozen at freeze", int'(frozen_o), 1);
    chk("R4 stamp", int'(stamp_o), c_det);
    chk("R4 channel mask", int'(trig_ch_o), int'(m));
    chk("R6 stop cell", int'(stop_cell_o), exp_stop);
    chk("R6 pointer after stop", int'(wr_ptr_o), (exp_stop + 1) % DEPTH);
    chk("R9 request", int'(rd_req_o), 1);
    if (noise) begin
      // R7: hits while frozen; R9: done while frozen ignored
      hit_i = ~m; rd_done_i = 1'b1;
      @(negedge clk_i); hit_i = '0; rd_done_i = 1'b0;
      repeat (2) @(negedge clk_i);
      chk("R7 frozen kept", int'(frozen_o), 1);
      chk("R9 done ignored when frozen", int'(rd_req_o), 1);
      chk("R7 stamp kept", int'(stamp_o), c_det);
      chk("R7 mask kept", int'(trig_ch_o), int'(m));
    end
    rd_ack_i = 1'b1;
    @(negedge clk_i); rd_ack_i = 1'b0;
    chk("R9 ack ends request", int'(rd_req_o), 0);
    chk("R9 readout frozen", int'(frozen_o), 1);
    if (noise) begin
      hit_i = m ^ 1; @(negedge clk_i); hit_i = '0;
      repeat (2) @(negedge clk_i);
      chk("R7 readout ignores hit", int'(frozen_o), 1);
      chk("R7 stop kept", int'(stop_cell_o), exp_stop);
      chk("R3 pointer held", int'(wr_ptr_o), (exp_stop + 1) % DEPTH);
    end
    rd_done_i = 1'b1;
    @(negedge clk_i); rd_done_i = 1'b0;
    chk("R9 re-armed", int'(frozen_o), 0);
    chk("R9 writing resumes", int'(wr_en_o), 1);
    p_det = int'(wr_ptr_o);
    @(negedge clk_i);
    chk("R3 pointer advance", int'(wr_ptr_o), (p_det + 1) % DEPTH);
    if (hold) begin
      delay_i = '0;
      repeat (4) @(negedge clk_i);
      chk("R8 held level no retrigger", int'(wr_en_o), 1);
      hit_i = '0;
    end
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk_i);
    chk("R1 ptr", int'(wr_ptr_o), 0);
    chk("R1 coarse", int'(coarse_o), 0);
    chk("R1 armed", int'(wr_en_o), 1);
    chk("R1 frozen", int'(frozen_o), 0);
    chk("R1 request", int'(rd_req_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 first count", int'(coarse_o), 1);
    // R9: ack while armed ignored
    rd_ack_i = 1'b1; @(negedge clk_i); rd_ack_i = 1'b0;
    @(negedge clk_i);
    chk("R9 ack ignored when armed", int'(wr_en_o), 1);
    // R2 wrap
    c0 = int'(coarse_o);
    repeat (5000) @(negedge clk_i);
    chk("R2 wrap", int'(coarse_o), (c0 + 5000) % (1 << CNT_W));
    // sweep delays over channels
    for (int d = 0; d <= 40; d++) run_rec(NUM_CH'(1 << (d % NUM_CH)), d, 1'b0, 1'b0);
    run_rec(4'b0110, 255, 1'b0, 1'b0);
    // R7/R10 noise and R8 held level
    run_rec(4'b0001, 10, 1'b1, 1'b0);
    run_rec(4'b1000, 0, 1'b1, 1'b0);
    run_rec(4'b0100, 5, 1'b0, 1'b1);
    run_rec(4'b1111, 3, 1'b0, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule